// File: doc/BRIEF.md
# One-Shot Underflow Interrupt Timer

This block is a down-counting interrupt timer for a cartridge memory controller that sits on an 8-bit CPU bus. Software fills a 16-bit reload value one byte at a time, then issues a control write. That write copies the reload value into the counter, arms or disarms counting from data bit 0, and drops any interrupt that is still asserted.

When armed, the counter loses one on each CPU clock. The interrupt fires on the cycle where the count wraps from zero to all ones, not on the cycle where it reaches zero. A reload value of N therefore gives an interrupt N+1 cycles after the arming write. The timer then disarms itself, and the interrupt stays high until software issues the next control write.

Top module: `irq_timer`

## Requirements
- R1: Writes take effect only when `addr_i` is 0x6000 or higher. The register is chosen by `addr_i[3:0]`. Writes below 0x6000 change nothing.
- R2: Index 0xB loads the low byte of the reload latch and index 0xC loads the high byte. The byte that is not written keeps its value. All other indices leave the latch unchanged.
- R3: A write to index 0xA clears `irq_o`, loads the counter from the latch, and sets the armed state to `data_i[0]`.
- R4: While armed, the counter decreases by one on every clock.
- R5: When an armed count steps from 0x0000 to 0xFFFF, `irq_o` goes high and the timer disarms. With latch value N, `irq_o` is first seen high N+1 clocks after the arming write.
- R6: Reset clears the armed state, the counter, the latch and `irq_o`.
- R7: Once high, `irq_o` stays high until the next index-0xA write. Latch writes do not clear it.
- R8: If an index-0xA write lands on a counting cycle, the write wins and the counter takes the latch value.
- R9: A control write with `data_i[0]` = 0 leaves the timer idle, and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench uses the default parameters: a 16-bit counter, an 8-bit data bus and a window base of 0x6000. With these values the distance to an interrupt can be measured directly for reload values 0, 1, 5, 0x0100 and 0x0123. That confirms the N+1 rule and shows that each latch byte lands in the right place. The same widths also allow writes just below the window base and to the indices next to the latch indices, so the decode boundaries are covered.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int unsigned IDX_W = 4;
  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL    = 4'hA,
    IDX_LATCH_0 = 4'hB,
    IDX_LATCH_1 = 4'hC
  } reg_idx_e;
endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ctrl_wr_o,
  output logic              ctrl_arm_o,
  output logic [CNT_W-1:0]  latch_o
);
  localparam int unsigned N_BYTES = CNT_W / DATA_W;

  logic             in_win;
  logic [IDX_W-1:0] idx;

  assign in_win     = wr_en_i && (addr_i >= WIN_BASE);
  assign idx        = addr_i[IDX_W-1:0];
  assign ctrl_wr_o  = in_win && (idx == IDX_CTRL);
  assign ctrl_arm_o = data_i[0];

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    logic [IDX_W-1:0] my_idx;
    assign my_idx = IDX_W'(IDX_LATCH_0) + IDX_W'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        latch_o[k*DATA_W +: DATA_W] <= '0;
      else if (in_win && idx == my_idx)   latch_o[k*DATA_W +: DATA_W] <= data_i;
    end
  end
endmodule

// File: rtl/irq_timer_counter.sv
module irq_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             irq_o
);
  logic wrap;
  assign wrap = armed_o && (cnt_o == '0);

  // control write wins over a counting step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      armed_o <= 1'b0;
      irq_o   <= 1'b0;
    end else if (load_i) begin
      cnt_o   <= load_val_i;
      armed_o <= arm_i;
      irq_o   <= 1'b0;
    end else if (armed_o) begin
      cnt_o <= cnt_o - 1'b1;
      if (wrap) begin
        armed_o <= 1'b0;
        irq_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              irq_o
);
  logic             ctrl_wr, ctrl_arm, armed_q;
  logic [CNT_W-1:0] latch_q, cnt_q;

  irq_timer_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .data_i,
    .ctrl_wr_o(ctrl_wr), .ctrl_arm_o(ctrl_arm), .latch_o(latch_q)
  );

  irq_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(ctrl_wr), .arm_i(ctrl_arm), .load_val_i(latch_q),
    .cnt_o(cnt_q), .armed_o(armed_q), .irq_o
  );
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic              armed,
  input logic [CNT_W-1:0]  latch
);
  logic hit, ctrl, lat;
  assign hit  = wr_en_i && (addr_i >= WIN_BASE);
  assign ctrl = hit && (addr_i[3:0] == 4'hA);
  assign lat  = hit && (addr_i[3:0] == 4'hB || addr_i[3:0] == 4'hC);

  assert_ctrl_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl |=> (!irq_o && cnt == $past(latch) && armed == $past(data_i[0])));
  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !ctrl) |=> (cnt == $past(cnt) - 1'b1));
  assert_fire_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !ctrl && cnt == '0) |=> (irq_o && !armed && cnt == '1));
  assert_irq_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ctrl) |=> irq_o);
  assert_latch_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat |=> $stable(latch));
  assert_idle_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !ctrl) |=> ($stable(cnt) && !armed));
endmodule

bind irq_timer irq_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .data_i, .irq_o,
  .cnt(cnt_q), .armed(armed_q), .latch(latch_q)
);

// File: tb/irq_timer_tb_top.sv
module irq_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_timer dut_i (.clk_i, .rst_ni, .wr_en_i, .addr_i, .data_i, .irq_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one write; returns at the negedge right after the write edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_latch(input logic [15:0] v);
    wr(16'h600B, v[7:0]);
    wr(16'h600C, v[15:8]);
  endtask

  // clocks from arming write until irq seen, capped
  task automatic time_irq(output int n, input int cap);
    n = 0;
    while (!irq_o && n < cap) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  task automatic t_reset;
    int n;
    check(irq_o == 1'b0, "R6 irq after reset", irq_o, 0);
    wr(16'h600A, 8'h01);             // latch still zero from reset
    time_irq(n, 10);
    check(n == 1, "R6 latch cleared -> 1 cycle", n, 1);
  endtask

  task automatic t_span(input logic [15:0] v, input string req);
    int n;
    set_latch(v);
    wr(16'h600A, 8'h01);
    check(irq_o == 1'b0, "R3 ack on arm", irq_o, 0);
    time_irq(n, 70000);
    check(n == int'(v) + 1, req, n, int'(v) + 1);
  endtask

  task automatic t_hold;
    wr(16'h600B, 8'h44);
    wr(16'h600C, 8'h00);
    idle(20);
    check(irq_o == 1'b1, "R7 irq held", irq_o, 1);
    wr(16'h600A, 8'h00);
    check(irq_o == 1'b0, "R3 control write clears irq", irq_o, 0);
    idle(300);
    check(irq_o == 1'b0, "R9 disarmed control gives no irq", irq_o, 0);
  endtask

  task automatic t_window;
    int n;
    set_latch(16'd3);
    wr(16'h5FFB, 8'h50);            // below window
    wr(16'h5FFA, 8'h01);            // below window: must not arm
    idle(20);
    check(irq_o == 1'b0, "R1 low ctrl ignored", irq_o, 0);
    wr(16'h600A, 8'h01);
    time_irq(n, 200);
    check(n == 4, "R1 low latch write ignored", n, 4);
  endtask

  task automatic t_bytes;
    int n;
    set_latch(16'h0105);
    wr(16'hE00B, 8'h07);            // high alias, low byte only
    wr(16'h600D, 8'hFF);
    wr(16'h6009, 8'hFF);
    wr(16'h6000, 8'hFF);
    wr(16'h600A, 8'h01);
    time_irq(n, 1000);
    check(n == 16'h0107 + 1, "R2 byte kept, neighbours ignored", n, 16'h0107 + 1);
  endtask

  task automatic t_rearm;
    int n;
    set_latch(16'd10);
    wr(16'h600A, 8'h01);
    idle(5);
    wr(16'h600A, 8'h01);            // lands while counting
    time_irq(n, 200);
    check(n == 11, "R8 rewrite reloads", n, 11);
    wr(16'h600A, 8'h01);
    idle(3);
    wr(16'h600A, 8'h00);
    idle(40);
    check(irq_o == 1'b0, "R9 disarm mid-count", irq_o, 0);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    t_reset();
    t_span(16'd0, "R5 N=0");
    t_span(16'd1, "R4 N=1");
    t_span(16'd5, "R5 N=5");
    t_span(16'h0100, "R2 high byte N=256");
    t_span(16'h0123, "R4 N=0x123");
    t_hold();
    t_window();
    t_bytes();
    t_rearm();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule